// File: doc/BRIEF.md
# Tile Layer Priority Compositor

This block merges, once per pixel, a background tile pixel and a sprite pixel into a 5-bit palette index. The background pixel brings a 4-bit colour, a palette-select bit and a priority bit. The sprite pixel brings a 4-bit colour and always draws from the upper palette. The backdrop index is used where nothing opaque is present, or where the pixel is blanked.

A blanked pixel is one where the display is switched off, or where left-column masking hides the first 8 pixels of a line. The block also forms the sprite line-buffer read address from the pixel column. That address can be moved 8 pixels further along the buffer, which shifts the whole sprite layer left. The sprite colour read at that address comes back in the same cycle. The chosen index is registered, so it appears one cycle after the input beat, together with a valid strobe.

Top module: `tile_compositor`

## Requirements
- R1: When the background priority bit is 1 and the background colour is nonzero, `pixOut` is `{bgPal, bgColor}`. This holds whatever the sprite colour is.
- R2: Otherwise, when the sprite colour is nonzero, `pixOut` is `{1'b1, sprColor}`. Bit 4 set means the second palette.
- R3: Otherwise, when the background colour is nonzero, `pixOut` is `{bgPal, bgColor}`. The priority bit does not matter here.
- R4: When both colours are zero, `pixOut` is `{1'b1, backdrop}`.
- R5: When `col0Mask` is 1 and `pixX` is below 8, `pixOut` is `{1'b1, backdrop}`. At `pixX` of 8 or more, the mask has no effect.
- R6: `sprAddr` equals `pixX + 8` when `sprShift` is 1, and `pixX` when it is 0. It is one bit wider than `pixX`, so it never wraps.
- R7: When `dispEn` is 0, every valid pixel gives `{1'b1, backdrop}`.
- R8: `pixOutValid` equals `pixValid` one cycle earlier. `pixOut` carries the result of that beat. After reset, both outputs are 0.
- R9: In a cycle where `pixValid` is 0, `pixOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Input beat strobe |
| pixX | input | 8 | Pixel column in the line |
| bgColor | input | 4 | Background colour, 0 is transparent |
| bgPal | input | 1 | Background palette select |
| bgPri | input | 1 | Background priority over sprites |
| sprColor | input | 4 | Sprite colour read at `sprAddr`, 0 is transparent |
| dispEn | input | 1 | Display enable |
| col0Mask | input | 1 | Blank the first 8 pixels of the line |
| sprShift | input | 1 | Sample sprites 8 pixels further along |
| backdrop | input | 4 | Backdrop colour, low 4 bits of the index |
| sprAddr | output | 9 | Sprite line-buffer read address |
| pixOut | output | 5 | Registered palette index |
| pixOutValid | output | 1 | Strobe for `pixOut` |

## Verification
The assertions assume two things about the inputs. First, `sprColor` settles in the same cycle as `sprAddr`, because it comes from a combinational line-buffer read. Second, the controls are sampled only on valid beats. The bench meets both. It models the sprite buffer as an array that is read combinationally at `sprAddr`. It changes every input only at the falling edge, so a beat's values are stable around the rising edge that captures them. The sweeps cover every combination of background colour, sprite colour, palette bit and priority bit, plus every column across the masked region.

// File: rtl/tile_compositor_pkg.sv
package tile_compositor_pkg;
  localparam int COLOR_W = 4;
  localparam int INDEX_W = COLOR_W + 1;

  typedef struct packed {
    logic fire;   // beat accepted this cycle
    logic blank;  // force backdrop
  } ctlStrobeT;
endpackage

// File: rtl/tile_compositor_ctrl.sv
module tile_compositor_ctrl
  import tile_compositor_pkg::*;
#(
  parameter int X_W     = 8,
  parameter int COL_PIX = 8
) (
  input  logic           pixValid,
  input  logic [X_W-1:0] pixX,
  input  logic           dispEn,
  input  logic           col0Mask,
  input  logic           sprShift,
  output logic [X_W:0]   sprAddr,
  output ctlStrobeT      ctl
);
  localparam logic [X_W:0] SHIFT_OFS = (X_W+1)'(COL_PIX);
  localparam logic [X_W-1:0] EDGE    = X_W'(COL_PIX);

  logic inFirstCol;

  always_comb begin
    inFirstCol = pixX < EDGE;
    ctl.fire   = pixValid;
    ctl.blank  = !dispEn || (col0Mask && inFirstCol);
    sprAddr    = {1'b0, pixX} + (sprShift ? SHIFT_OFS : '0);
  end
endmodule

// File: rtl/tile_compositor_dp.sv
module tile_compositor_dp
  import tile_compositor_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          ctl,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               bgPal,
  input  logic               bgPri,
  input  logic [COLOR_W-1:0] sprColor,
  input  logic [COLOR_W-1:0] backdrop,
  output logic [INDEX_W-1:0] pixOut,
  output logic               pixOutValid
);
  logic               bgOpaque;
  logic               sprOpaque;
  logic [INDEX_W-1:0] pick;

  always_comb begin
    bgOpaque  = |bgColor;
    sprOpaque = |sprColor;
    if (ctl.blank)              pick = {1'b1, backdrop};
    else if (bgPri && bgOpaque) pick = {bgPal, bgColor};
    else if (sprOpaque)         pick = {1'b1, sprColor};
    else if (bgOpaque)          pick = {bgPal, bgColor};
    else                        pick = {1'b1, backdrop};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOutValid <= ctl.fire;
      if (ctl.fire) pixOut <= pick;
    end
  end
endmodule

// File: rtl/tile_compositor.sv
module tile_compositor
  import tile_compositor_pkg::*;
#(
  parameter int X_W     = 8,
  parameter int COL_PIX = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixValid,
  input  logic [X_W-1:0] pixX,
  input  logic [3:0]     bgColor,
  input  logic           bgPal,
  input  logic           bgPri,
  input  logic [3:0]     sprColor,
  input  logic           dispEn,
  input  logic           col0Mask,
  input  logic           sprShift,
  input  logic [3:0]     backdrop,
  output logic [X_W:0]   sprAddr,
  output logic [4:0]     pixOut,
  output logic           pixOutValid
);
  ctlStrobeT ctl;

  tile_compositor_ctrl #(.X_W(X_W), .COL_PIX(COL_PIX)) u_ctrl (
    .pixValid(pixValid), .pixX(pixX), .dispEn(dispEn), .col0Mask(col0Mask),
    .sprShift(sprShift), .sprAddr(sprAddr), .ctl(ctl)
  );

  tile_compositor_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bgColor(bgColor), .bgPal(bgPal),
    .bgPri(bgPri), .sprColor(sprColor), .backdrop(backdrop),
    .pixOut(pixOut), .pixOutValid(pixOutValid)
  );
endmodule

// File: rtl/tile_compositor_chk.sv
module tile_compositor_chk #(
  parameter int X_W     = 8,
  parameter int COL_PIX = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           pixValid,
  input logic [X_W-1:0] pixX,
  input logic [3:0]     bgColor,
  input logic           bgPal,
  input logic           bgPri,
  input logic [3:0]     sprColor,
  input logic           dispEn,
  input logic           col0Mask,
  input logic           sprShift,
  input logic [3:0]     backdrop,
  input logic [X_W:0]   sprAddr,
  input logic [4:0]     pixOut,
  input logic           pixOutValid
);
  logic inEdge;
  assign inEdge = int'(pixX) < COL_PIX;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid); // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !pixOutValid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> $stable(pixOut)); // R9
  AST_DISPLAY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !dispEn) |=> (pixOut == {1'b1, $past(backdrop)})); // R7
  AST_EDGE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && col0Mask && inEdge) |=> (pixOut == {1'b1, $past(backdrop)})); // R5
  AST_BG_OVER: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && dispEn && !(col0Mask && inEdge) && bgPri && bgColor != 0)
    |=> (pixOut == {$past(bgPal), $past(bgColor)})); // R1
  AST_SPR_PAL: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && dispEn && !(col0Mask && inEdge) && !(bgPri && bgColor != 0) && sprColor != 0)
    |=> (pixOut == {1'b1, $past(sprColor)})); // R2
  AST_SHIFT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    sprShift |-> (int'(sprAddr) == int'(pixX) + COL_PIX)); // R6
endmodule

bind tile_compositor tile_compositor_chk #(.X_W(X_W), .COL_PIX(COL_PIX)) u_chk (.*);

// File: tb/tile_compositor_bench.sv
module tile_compositor_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixX = '0;
  logic [3:0] bgColor = '0;
  logic       bgPal = 1'b0;
  logic       bgPri = 1'b0;
  logic [3:0] sprColor;
  logic       dispEn = 1'b1;
  logic       col0Mask = 1'b0;
  logic       sprShift = 1'b0;
  logic [3:0] backdrop = 4'h9;
  logic [8:0] sprAddr;
  logic [4:0] pixOut;
  logic       pixOutValid;
  logic [3:0] spriteBuf [0:511];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sprColor = spriteBuf[sprAddr];

  tile_compositor u_tile_compositor (.*);

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [4:0] model(input logic [3:0] bg, input logic pal, input logic pri,
                                       input logic [3:0] spr, input logic disp, input logic msk,
                                       input logic [7:0] x, input logic [3:0] bd);
    if (!disp || (msk && x < 8)) return {1'b1, bd};
    if (pri && bg != 0) return {pal, bg};
    if (spr != 0) return {1'b1, spr};
    if (bg != 0) return {pal, bg};
    return {1'b1, bd};
  endfunction

  // drive one beat at the falling edge, sample at the next falling edge
  task automatic beat(input string req, input logic [7:0] x, input logic [3:0] bg,
                      input logic pal, input logic pri, input logic [3:0] spr);
    logic [4:0] exp;
    pixX = x; bgColor = bg; bgPal = pal; bgPri = pri; pixValid = 1'b1;
    if (!sprShift) spriteBuf[{1'b0, x}] = spr;
    exp = model(bg, pal, pri, spriteBuf[{1'b0, x} + (sprShift ? 9'd8 : 9'd0)],
                dispEn, col0Mask, x, backdrop);
    @(posedge clk); @(negedge clk);
    check(req, pixOut, exp);
    check("R8 valid", pixOutValid, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 512; a++) spriteBuf[a] = 4'((a * 5) + 1);
    @(negedge clk); @(negedge clk);
    check("R8 reset valid", pixOutValid, 0);
    check("R8 reset index", pixOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: exhaustive colour, palette and priority sweep
    for (int b = 0; b < 16; b++)
      for (int s = 0; s < 16; s++)
        for (int p = 0; p < 4; p++)
          beat("R1/R2/R3/R4 sweep", 8'd100, 4'(b), p[0], p[1], 4'(s));

    // R5: mask across the first columns and beyond
    col0Mask = 1'b1;
    for (int x = 0; x < 16; x++) beat("R5 masked", 8'(x), 4'h5, 1'b0, 1'b1, 4'h3);
    col0Mask = 1'b0;
    beat("R5 unmasked", 8'd3, 4'h5, 1'b0, 1'b1, 4'h3);

    // R6: shifted sprite sampling
    sprShift = 1'b1;
    pixX = 8'd30;
    #1 check("R6 shifted address", sprAddr, 38);
    beat("R6 shifted sample", 8'd30, 4'h0, 1'b0, 1'b0, 4'h0);
    pixX = 8'd255;
    #1 check("R6 top address", sprAddr, 263);
    sprShift = 1'b0;
    #1 check("R6 plain address", sprAddr, 255);

    // R7: display off blanks opaque pixels
    dispEn = 1'b0;
    backdrop = 4'h2;
    beat("R7 display off", 8'd50, 4'hF, 1'b1, 1'b1, 4'hE);
    beat("R7 display off spr", 8'd60, 4'h0, 1'b0, 1'b0, 4'h7);
    dispEn = 1'b1;

    // R9: idle beat keeps previous index
    beat("R9 setup", 8'd70, 4'hA, 1'b0, 1'b0, 4'h0);
    pixValid = 1'b0; bgColor = 4'h1; bgPal = 1'b1; dispEn = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 hold", pixOut, 5'h0A);
    check("R8 idle valid", pixOutValid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule